// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address stream for short bursts of memory access. The caller presents a base address with the advance strobe low. On each later cycle that the strobe is high, the block steps the lowest address bits to the next burst position. The upper bits stay at the loaded value, and the position wraps within a group of four addresses. Two orderings are available: a linear count, and an interleaved order that XORs the beat number into the loaded low bits.

The read/write type and the selected state are captured together with the base address. Both then stay fixed for the whole burst. During an advance the chip-select and write-strobe inputs are not looked at, so a burst that began deselected stays invalid until the next load. A stall input freezes every register. All outputs are registered and appear one clock after the edge that accepted the command.

Top module: `burst_addr_seq`

## Requirements
- R1: With linear order latched, the low BEAT_W output bits after n advances equal (loaded low bits + n) modulo 2**BEAT_W.
- R2: With interleaved order latched, the low BEAT_W output bits after n advances equal the loaded low bits XOR n.
- R3: During advances, address bits above BEAT_W stay equal to the loaded base.
- R4: On a non-stalled edge with `advance`=0, `addr_out` equals `addr_in` of that edge from the next cycle on, and the beat count restarts at 0.
- R5: `is_write` becomes 1 when a selected load sees `write_n`=0 and 0 when it sees `write_n`=1. It keeps that value during advances whatever `write_n` and `chip_sel` do.
- R6: While `stall`=1, `addr_out`, `is_write` and `valid` keep their values.
- R7: `valid` becomes 1 only on a load with every `chip_sel` bit at 1. A load with any bit at 0 gives `valid`=0 and `is_write`=0, and advancing never sets `valid`.
- R8: After 2**BEAT_W advances the address returns to the loaded base, and further advances repeat the same group.
- R9: Synchronous active-high `rst` clears `addr_out`, `is_write` and `valid` to 0.
- R10: `order_sel` (0 = linear, 1 = interleaved) is sampled only at a load. Changes during advances do not alter the ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | 1 = hold all state this edge |
| advance | input | 1 | 0 = load base address, 1 = step burst |
| order_sel | input | 1 | 0 = linear, 1 = interleaved, sampled at load |
| chip_sel | input | SEL_W | Chip selects, all ones = selected |
| write_n | input | 1 | 0 = write access, sampled at load |
| addr_in | input | ADDR_W | External base address |
| addr_out | output | ADDR_W | Current burst address |
| is_write | output | 1 | Latched access type of the burst |
| valid | output | 1 | Current beat belongs to a selected access |

## Verification
A wrong beat counter or a wrong latched order shows up as a bad `addr_out` one cycle after the advance that uses it. A beat that is one too many or too few stays visible on every later beat until the next load. A corrupted base shows in the upper bits on the first advance. A type or select flag that leaks from the live inputs shows on `is_write` or `valid` after the first advance in which `write_n` or `chip_sel` differ from their load-time values. Any state that moves during a stall shows at the output on the very next cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_t;
endpackage

// File: rtl/burst_lowbits_calc.sv
module burst_lowbits_calc
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_t            ord,
  input  logic [BEAT_W-1:0] base_lo,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] lo
);
  always_comb begin
    if (ord == ORD_XOR) lo = base_lo ^ beat;
    else                lo = base_lo + beat;
  end
endmodule

// File: rtl/burst_ctl_reg.sv
module burst_ctl_reg
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic              sel_ok,
  input  logic              wr_req,
  input  order_t            ord_in,
  output logic [BEAT_W-1:0] beat_q,
  output logic [BEAT_W-1:0] beat_inc,
  output order_t            ord_q,
  output logic              wr_q,
  output logic              act_q
);
  assign beat_inc = beat_q + BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      ord_q  <= ORD_LINEAR;
      wr_q   <= 1'b0;
      act_q  <= 1'b0;
    end else if (en) begin
      if (load) begin
        beat_q <= '0;
        ord_q  <= ord_in;
        act_q  <= sel_ok;
        wr_q   <= sel_ok & wr_req;
      end else begin
        beat_q <= beat_inc;
      end
    end
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BEAT_W-1:0] lo_nxt,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      addr_q <= '0;
    end else if (en) begin
      if (load) begin
        base_q <= addr_in;
        addr_q <= addr_in;
      end else begin
        addr_q <= {base_q[ADDR_W-1:BEAT_W], lo_nxt};
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [SEL_W-1:0]  chip_sel,
  input  logic              write_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              is_write,
  output logic              valid
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic              en, load, sel_ok;
  logic [BEAT_W-1:0] beat_q, beat_inc, lo_nxt;
  logic [ADDR_W-1:0] base_q;
  order_t            ord_in, ord_q;

  assign en     = ~stall;
  assign load   = ~advance;
  assign sel_ok = &chip_sel;
  assign ord_in = order_t'(order_sel);

  burst_ctl_reg #(.BEAT_W(BEAT_W)) u_ctl (
    .clk(clk), .rst(rst), .en(en), .load(load), .sel_ok(sel_ok),
    .wr_req(~write_n), .ord_in(ord_in), .beat_q(beat_q),
    .beat_inc(beat_inc), .ord_q(ord_q), .wr_q(is_write), .act_q(valid)
  );

  burst_lowbits_calc #(.BEAT_W(BEAT_W)) u_calc (
    .ord(ord_q), .base_lo(base_q[BEAT_W-1:0]), .beat(beat_inc), .lo(lo_nxt)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr (
    .clk(clk), .rst(rst), .en(en), .load(load), .addr_in(addr_in),
    .lo_nxt(lo_nxt), .base_q(base_q), .addr_q(addr_out)
  );

  // R6
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(addr_out) && $stable(is_write) && $stable(valid));
  // R4
  a_r4_load_addr: assert property (@(posedge clk) disable iff (rst)
    (!stall && !advance) |=> addr_out == $past(addr_in));
  // R3
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!stall && advance) |=> addr_out[ADDR_W-1 -: UP_W] == $past(addr_out[ADDR_W-1 -: UP_W]));
  // R5
  a_r5_type_kept: assert property (@(posedge clk) disable iff (rst)
    (!stall && advance) |=> is_write == $past(is_write));
  // R7
  a_r7_no_revive: assert property (@(posedge clk) disable iff (rst)
    (!stall && advance && !valid) |=> !valid);
  // R7
  a_r7_write_needs_sel: assert property (@(posedge clk) disable iff (rst)
    is_write |-> valid);
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 20;
  localparam int BW = 2;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          stall, advance, order_sel, write_n;
  logic [SW-1:0] chip_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          is_write, valid;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [AW-1:0] m_base, m_addr;
  logic [BW-1:0] m_beat;
  logic          m_ord, m_wr, m_act;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(BW), .SEL_W(SW)) i_burst_addr_seq (
    .clk(clk), .rst(rst), .stall(stall), .advance(advance),
    .order_sel(order_sel), .chip_sel(chip_sel), .write_n(write_n),
    .addr_in(addr_in), .addr_out(addr_out), .is_write(is_write), .valid(valid)
  );

  function automatic logic [BW-1:0] exp_lo(logic ord, logic [BW-1:0] b, logic [BW-1:0] n);
    return ord ? (b ^ n) : (b + n);
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic st, logic adv, logic ord, logic [SW-1:0] sel,
                      logic wn, logic [AW-1:0] a, string tag);
    @(negedge clk);
    stall = st; advance = adv; order_sel = ord; chip_sel = sel;
    write_n = wn; addr_in = a;
    @(posedge clk);
    if (!st) begin
      if (!adv) begin
        m_base = a; m_beat = '0; m_ord = ord; m_act = &sel;
        m_wr = m_act & ~wn; m_addr = a;
      end else begin
        m_beat = m_beat + 1'b1;
        m_addr = {m_base[AW-1:BW], exp_lo(m_ord, m_base[BW-1:0], m_beat)};
      end
    end
    #2;
    chk(tag, addr_out, m_addr);
    chk("R5 is_write", AW'(is_write), AW'(m_wr));
    chk("R7 valid", AW'(valid), AW'(m_act));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; stall = 0; advance = 0; order_sel = 0; chip_sel = '1;
    write_n = 1; addr_in = 20'hABCDE;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 addr", addr_out, '0);
    chk("R9 is_write", AW'(is_write), '0);
    chk("R9 valid", AW'(valid), '0);
    @(negedge clk); rst = 0;
    m_base = '0; m_addr = '0; m_beat = '0; m_ord = 0; m_wr = 0; m_act = 0;

    // R1, R8: linear from low bits 2 -> 3,0,1,2,3
    step(0, 0, 0, '1, 0, 20'h12342, "R4 load");
    for (int i = 0; i < 5; i++) step(0, 1, 0, '1, 1, 20'h00000, "R1 R8 linear");
    // R2, R10: interleaved from 1 -> 0,3,2,1 while order_sel toggles
    step(0, 0, 1, '1, 1, 20'hF00F1, "R4 load");
    for (int i = 0; i < 5; i++) step(0, 1, i[0], '0, 0, 20'h0, "R2 R10 interleaved");
    // R3: upper bits fixed
    step(0, 0, 0, '1, 0, 20'hFFFFF, "R4 load");
    step(0, 1, 0, 3'b010, 1, 20'h00000, "R3 upper");
    // R6: stall with changing inputs
    step(1, 0, 1, '1, 1, 20'h55555, "R6 stall");
    step(1, 1, 1, '0, 0, 20'h0AAAA, "R6 stall");
    // R7: deselected load, then advance with selects high
    step(0, 0, 0, 3'b101, 0, 20'h00010, "R7 deselect");
    step(0, 1, 0, '1, 0, 20'h00000, "R7 advance");

    for (int i = 0; i < 3000; i++) begin
      logic st, adv;
      logic [SW-1:0] sel;
      st  = ($urandom % 8) == 0;
      adv = ($urandom % 4) != 0;
      sel = ($urandom % 3) == 0 ? SW'($urandom) : '1;
      step(st, adv, 1'($urandom), sel, 1'($urandom), AW'($urandom),
           st ? "R6 rand" : (!adv ? "R4 rand" : (m_ord ? "R2 rand" : "R1 rand")));
    end
    summary();
  end
endmodule